// File: doc/BRIEF.md
# Serial Control-Word Register Receiver

This block is the receive end of a three-wire serial link. A host uses the link to program the register file of a waveform generator. The serial clock, the serial data line and the active-low frame strobe come from another clock domain. The block samples all three on a fast system clock through two-stage synchronizers. It finds the falling edges of the serial clock in the system clock domain and shifts in one data bit on each falling edge, most significant bit first, while the frame strobe is low. Every sixteen bits form one control word.

Each complete word is classified by its top bits and applied in one of three ways:

- A control word sets the core reset flag, the waveform-select bits and the frequency write mode.
- A frequency word writes 14 bits of the 28-bit frequency register. In consecutive-write mode, two frequency words in a row (low half first) load the whole 28-bit value at once. The first half waits in a staging register until the second half arrives.
- A phase word loads the 12-bit phase register.

The outputs are the current register contents and a one-cycle strobe for each completed word. The downstream accumulator and waveform logic read these outputs.

Top module: `ctlword_rx`

## Requirements
- R1: After system reset, freq_word and phase_word are zero, core_reset is 1, wave_sel is 0, and no frequency half is pending.
- R2: While frame_n_in is low, one bit of sdi_in is shifted in on each falling edge of sck_in, most significant bit first. The sixteenth bit completes a word.
- R3: A word whose bits 15:14 are 00 is a control word. Bit 8 drives core_reset. Bit 13 turns consecutive-write mode on. Bit 12 selects the half for a single frequency write. wave_sel takes {bit 5, bit 3, bit 1}.
- R4: word_done is high for exactly one system clock for each completed word. The output registers change only in that cycle.
- R5: In consecutive-write mode, the first word with bits 15:14 = 01 supplies frequency bits 13:0 and the second supplies bits 27:14. For example, 0x69F1 followed by 0x4000 gives 0x00029F1.
- R6: In consecutive-write mode, freq_word does not change after the first half; the first half is held in a staging register.
- R7: With consecutive-write mode off, a frequency word replaces bits 27:14 when control bit 12 is 1, and bits 13:0 when it is 0. The other half is kept.
- R8: A word whose bits 15:13 are 110 loads its bits 11:0 into phase_word.
- R9: If frame_n_in rises before sixteen bits have arrived, the partial word is discarded and no word_done is produced. A pending frequency half is kept, and the next frame starts a fresh word.
- R10: A complete word whose bits 15:14 are 10, or whose bits 15:13 are 111, produces word_done but changes no register.
- R11: A control word discards any pending frequency half, so the next frequency word is again treated as a first half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial clock from the host, idles high |
| sdi_in | input | 1 | Serial data from the host |
| frame_n_in | input | 1 | Active-low frame strobe from the host |
| freq_word | output | 28 | Current frequency register |
| phase_word | output | 12 | Current phase register |
| core_reset | output | 1 | Reset flag from the last control word |
| wave_sel | output | 3 | Waveform-select bits from the last control word |
| word_done | output | 1 | One-cycle strobe when a word has been applied |

## Verification
The assertions assume that the serial clock holds each level for at least two system clocks. Otherwise, falling edges can be lost and two words can finish in adjacent cycles. They also assume that the frame strobe changes only while the serial clock is high, so that no frame edge falls on a serial clock edge. The stimulus holds each serial clock level for four system clocks. It moves data and the frame strobe only while the serial clock is high, with a margin of four system clocks. This keeps every word at least 128 system clocks long, so the one-cycle strobe and the quiet-output properties can always hold.

// File: rtl/ctlword_rx_pkg.sv
`timescale 1ns/1ps
package ctlword_rx_pkg;

   typedef enum logic [1:0] {
      KIND_CTRL  = 2'd0,
      KIND_FREQ  = 2'd1,
      KIND_PHASE = 2'd2,
      KIND_NONE  = 2'd3
   } word_kind_e;

   // control-word field positions (the word format depends on them)
   localparam int CTL_CONSEC_BIT = 13;
   localparam int CTL_HALF_BIT   = 12;
   localparam int CTL_RESET_BIT  = 8;
   localparam int CTL_WAVE_HI    = 5;
   localparam int CTL_WAVE_MID   = 3;
   localparam int CTL_WAVE_LO    = 1;
   localparam int WAVE_W         = 3;

   function automatic word_kind_e classify(input logic [2:0] top3);
      word_kind_e k;
      case (top3[2:1])
         2'b00:   k = KIND_CTRL;
         2'b01:   k = KIND_FREQ;
         2'b11:   k = top3[0] ? KIND_NONE : KIND_PHASE;
         default: k = KIND_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ctlword_rx_sync.sv
`timescale 1ns/1ps
module ctlword_rx_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctlword_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/ctlword_rx_shift.sv
`timescale 1ns/1ps
module ctlword_rx_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              sdi_s,
   input  logic              frm_n_s,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);

   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("ctlword_rx_shift: WORD_W too small");
      end
   endgenerate

   logic              sck_q;
   logic              sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-2:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b1;
      else        sck_q <= sck_s;
   end

   assign sck_fall = sck_q & ~sck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= 1'b0;
         if (frm_n_s) begin
            bit_cnt <= '0;
         end else if (sck_fall) begin
            shreg <= {shreg[WORD_W-3:0], sdi_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               word     <= {shreg, sdi_s};
               word_vld <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ctlword_rx_decode.sv
`timescale 1ns/1ps
module ctlword_rx_decode
   import ctlword_rx_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int FREQ_W  = 28,
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_vld,
   input  logic [WORD_W-1:0]  word,
   output logic [FREQ_W-1:0]  freq_word,
   output logic [PHASE_W-1:0] phase_word,
   output logic               core_reset,
   output logic [WAVE_W-1:0]  wave_sel,
   output logic               word_done,
   output logic               half_pend
);

   localparam int HALF_W = FREQ_W / 2;

   generate
      if (HALF_W != WORD_W - 2 || FREQ_W % 2 != 0) begin : g_bad_freq
         $error("ctlword_rx_decode: FREQ_W must be 2*(WORD_W-2)");
      end
      if (PHASE_W > WORD_W - 4) begin : g_bad_phase
         $error("ctlword_rx_decode: PHASE_W must fit below the tag bits");
      end
   endgenerate

   word_kind_e        kind;
   logic [HALF_W-1:0] half_data;
   logic [HALF_W-1:0] stage_lo;
   logic              consec_mode;
   logic              half_upper;

   assign kind      = classify(word[WORD_W-1 -: 3]);
   assign half_data = word[HALF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_word   <= '0;
         phase_word  <= '0;
         core_reset  <= 1'b1;
         wave_sel    <= '0;
         word_done   <= 1'b0;
         half_pend   <= 1'b0;
         stage_lo    <= '0;
         consec_mode <= 1'b0;
         half_upper  <= 1'b0;
      end else begin
         word_done <= word_vld;
         if (word_vld) begin
            unique case (kind)
               KIND_CTRL: begin
                  consec_mode <= word[CTL_CONSEC_BIT];
                  half_upper  <= word[CTL_HALF_BIT];
                  core_reset  <= word[CTL_RESET_BIT];
                  wave_sel    <= {word[CTL_WAVE_HI], word[CTL_WAVE_MID],
                                  word[CTL_WAVE_LO]};
                  half_pend   <= 1'b0;
               end
               KIND_FREQ: begin
                  if (consec_mode) begin
                     if (!half_pend) begin
                        stage_lo  <= half_data;
                        half_pend <= 1'b1;
                     end else begin
                        freq_word <= {half_data, stage_lo};
                        half_pend <= 1'b0;
                     end
                  end else if (half_upper) begin
                     freq_word[FREQ_W-1:HALF_W] <= half_data;
                  end else begin
                     freq_word[HALF_W-1:0] <= half_data;
                  end
               end
               KIND_PHASE: phase_word <= word[PHASE_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctlword_rx.sv
`timescale 1ns/1ps
module ctlword_rx
   import ctlword_rx_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int FREQ_W      = 28,
   parameter int PHASE_W     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_in,
   input  logic               sdi_in,
   input  logic               frame_n_in,
   output logic [FREQ_W-1:0]  freq_word,
   output logic [PHASE_W-1:0] phase_word,
   output logic               core_reset,
   output logic [2:0]         wave_sel,
   output logic               word_done
);

   generate
      if (WAVE_W != 3) begin : g_bad_wave
         $error("ctlword_rx: wave_sel width mismatch");
      end
   endgenerate

   // sync order: {sck, sdi, frame_n}; clock and frame idle high
   logic [2:0]        sync_q;
   logic              word_vld;
   logic [WORD_W-1:0] word;
   logic              half_pend;

   ctlword_rx_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b101)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({sck_in, sdi_in, frame_n_in}),
      .q_sync  (sync_q)
   );

   ctlword_rx_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sync_q[2]),
      .sdi_s    (sync_q[1]),
      .frm_n_s  (sync_q[0]),
      .word_vld (word_vld),
      .word     (word)
   );

   ctlword_rx_decode #(
      .WORD_W  (WORD_W),
      .FREQ_W  (FREQ_W),
      .PHASE_W (PHASE_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_vld   (word_vld),
      .word       (word),
      .freq_word  (freq_word),
      .phase_word (phase_word),
      .core_reset (core_reset),
      .wave_sel   (wave_sel),
      .word_done  (word_done),
      .half_pend  (half_pend)
   );

endmodule

// File: rtl/ctlword_rx_checker.sv
`timescale 1ns/1ps
module ctlword_rx_checker #(
   parameter int FREQ_W  = 28,
   parameter int PHASE_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [FREQ_W-1:0]  freq_word,
   input logic [PHASE_W-1:0] phase_word,
   input logic               core_reset,
   input logic [2:0]         wave_sel,
   input logic               word_done,
   input logic               half_pend
);

   // R4: the completion strobe never lasts two cycles
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> !word_done);

   // R4: frequency register moves only with a completed word
   a_r4_freq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |-> $stable(freq_word));

   // R8: phase register moves only with a completed word
   a_r8_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |-> $stable(phase_word));

   // R3: control outputs move only with a completed word
   a_r3_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |-> $stable({core_reset, wave_sel}));

   // R6: capturing a first half leaves the visible frequency alone
   a_r6_first_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && $rose(half_pend)) |-> $stable(freq_word));

endmodule

bind ctlword_rx ctlword_rx_checker #(
   .FREQ_W  (FREQ_W),
   .PHASE_W (PHASE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .freq_word  (freq_word),
   .phase_word (phase_word),
   .core_reset (core_reset),
   .wave_sel   (wave_sel),
   .word_done  (word_done),
   .half_pend  (half_pend)
);

// File: tb/sim_ctlword_rx.sv
`timescale 1ns/1ps
module sim_ctlword_rx;

   localparam int HALF = 4;  // system clocks per serial clock level

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b1;
   logic        sdi = 1'b0;
   logic        frm_n = 1'b1;
   logic [27:0] freq_word;
   logic [11:0] phase_word;
   logic        core_reset;
   logic [2:0]  wave_sel;
   logic        word_done;

   int n_checks = 0;
   int n_fail   = 0;
   int n_done   = 0;

   always #2.5 clk = ~clk;

   ctlword_rx u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_in     (sck),
      .sdi_in     (sdi),
      .frame_n_in (frm_n),
      .freq_word  (freq_word),
      .phase_word (phase_word),
      .core_reset (core_reset),
      .wave_sel   (wave_sel),
      .word_done  (word_done)
   );

   always @(posedge clk) if (rst_n && word_done) n_done <= n_done + 1;

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] w, input int nbits);
      frm_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdi = w[15-i];
         wait_clk(HALF);
         sck = 1'b0;
         wait_clk(HALF);
         sck = 1'b1;
      end
      wait_clk(HALF);
      frm_n = 1'b1;
      wait_clk(3*HALF);
   endtask

   task automatic send_word(input logic [15:0] w);
      send_bits(w, 16);
   endtask

   task automatic t_reset();
      check("R1 freq", 32'(freq_word), 32'h0);
      check("R1 phase", 32'(phase_word), 32'h0);
      check("R1 core_reset", 32'(core_reset), 32'h1);
      check("R1 wave_sel", 32'(wave_sel), 32'h0);
      check("R4 no strobe at reset", 32'(n_done), 32'h0);
   endtask

   task automatic t_consec();
      int d0;
      d0 = n_done;
      send_word(16'h2100);
      check("R3 reset flag set", 32'(core_reset), 32'h1);
      check("R2 R4 one strobe per word", 32'(n_done - d0), 32'h1);
      send_word(16'h69F1);
      check("R6 first half not visible", 32'(freq_word), 32'h0);
      send_word(16'h4000);
      check("R5 two halves combined", 32'(freq_word), 32'h00029F1);
      check("R4 three strobes", 32'(n_done - d0), 32'h3);
   endtask

   task automatic t_phase();
      send_word(16'hC123);
      check("R8 phase load", 32'(phase_word), 32'h123);
      send_word(16'hC000);
      check("R8 phase zero", 32'(phase_word), 32'h0);
   endtask

   task automatic t_single_half();
      send_word(16'h1000);
      send_word(16'h5ABC);
      check("R7 upper half replaced", 32'(freq_word), 32'h6AF29F1);
      send_word(16'h0000);
      send_word(16'h4123);
      check("R7 lower half replaced", 32'(freq_word), 32'h6AF0123);
   endtask

   task automatic t_partial();
      int d0;
      send_word(16'h2000);
      check("R3 reset flag cleared", 32'(core_reset), 32'h0);
      send_word(16'h4001);
      d0 = n_done;
      send_bits(16'hC7FF, 7);
      check("R9 partial gives no strobe", 32'(n_done - d0), 32'h0);
      check("R9 partial leaves phase", 32'(phase_word), 32'h0);
      send_word(16'h4002);
      check("R9 pending half kept", 32'(freq_word), 32'h0008001);
   endtask

   task automatic t_ctrl_clears();
      send_word(16'h2000);
      send_word(16'h4005);
      check("R6 first half held", 32'(freq_word), 32'h0008001);
      send_word(16'h2000);
      send_word(16'h4006);
      send_word(16'h4007);
      check("R11 pending half dropped", 32'(freq_word), 32'h001C006);
   endtask

   task automatic t_ignored();
      int d0;
      d0 = n_done;
      send_word(16'h8FFF);
      send_word(16'hE555);
      check("R10 strobes still given", 32'(n_done - d0), 32'h2);
      check("R10 freq unchanged", 32'(freq_word), 32'h001C006);
      check("R10 phase unchanged", 32'(phase_word), 32'h0);
      check("R10 control unchanged", 32'({core_reset, wave_sel}), 32'h0);
   endtask

   task automatic t_wave();
      send_word(16'h002A);
      check("R3 wave bits 5,3,1", 32'(wave_sel), 32'h7);
      send_word(16'h0128);
      check("R3 wave and reset", 32'({core_reset, wave_sel}), 32'hE);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_consec();
      t_phase();
      t_single_half();
      t_partial();
      t_ctrl_clears();
      t_ignored();
      t_wave();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule